// File: doc/BRIEF.md
# Sync-Derived Line Window Generator

This block turns a sampled, active-low composite sync signal into per-line timing windows for a video path clocked at pixel rate. On each trailing (rising) edge of sync it opens a back-porch window of fixed length. When that window closes, an active-video window of fixed length opens at once, and a one-cycle line strobe marks its first cycle for downstream line counting.

The active-video window cannot be retriggered. Sync-like pulses that appear inside the picture area are ignored, so they open no back-porch window and do not extend the line. Vertical sync is found by a saturating up/down integrator, which rises while sync is low and falls while it is high. Because the broad field pulses hold sync low most of the time, the integrator climbs past an upper threshold and sets the vertical indication. The indication clears again only when the count drops to a lower threshold.

All window lengths and thresholds are parameters given in clock cycles. The defaults suit a 64 µs line sampled at 13.5 MHz. The sync input passes through a synchronizer chain before its edges are detected.

Top module: `sync_line_windows`

## Requirements
- R1: While `rst_n` is low, `porch_o`, `active_o`, `line_stb_o` and `vsync_o` are 0, and the integrator count is 0.
- R2: After reset no window opens until the synchronized sync input shows a 0-to-1 transition. A rising edge of `csync_n` sampled at clock edge k drives `porch_o` high after edge k+SYNC_STAGES.
- R3: `porch_o` stays high for exactly BP_CYCLES cycles unless R4 restarts it. In the cycle after it falls, `active_o` is high, and it stays high for exactly ACT_CYCLES cycles. `porch_o` and `active_o` are never high together.
- R4: With PORCH_RETRIG=1, a sync rising edge seen while the back-porch window is open restarts that window at its full length. With PORCH_RETRIG=0, such an edge has no effect.
- R5: A sync rising edge seen while `active_o` is high is ignored. It opens no back-porch window and does not change when the active window ends.
- R6: After the active window ends, both windows stay low until the next sync rising edge.
- R7: `line_stb_o` is high for exactly one cycle, which is the first cycle of each active window, and at no other time.
- R8: The integrator count goes up by one on each cycle where synchronized sync is 0 and down by one where it is 1. It saturates at INT_MAX and at 0.
- R9: `vsync_o` sets in the cycle after the count is at least VS_ON, clears in the cycle after the count is at most VS_OFF, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sampled composite sync, low during sync |
| porch_o | output | 1 | Back-porch window |
| active_o | output | 1 | Active-video window |
| line_stb_o | output | 1 | One-cycle strobe at the start of each active window |
| vsync_o | output | 1 | Vertical sync indication |

## Verification
The assertions assume that `csync_n` is a level that changes at most once per clock and rests high during reset. The bench meets this by driving sync only on falling clock edges and by holding it high until reset has been released.

The cascade and exclusion properties also assume that lines are long enough for the active window to end before the next genuine sync edge. The stimulus therefore uses line lengths that exceed the back-porch and active lengths together.

Spurious pulses, a second rising edge inside the back porch, and broad field pulses are all placed at offsets chosen so that each of them falls in the intended window.

// File: rtl/lw_pkg.sv
package lw_pkg;
   typedef enum logic [1:0] {
      TMR_IDLE   = 2'd0,
      TMR_PORCH  = 2'd1,
      TMR_ACTIVE = 2'd2
   } tmr_state_e;

   function automatic int unsigned lw_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/lw_sync_edge.sv
module lw_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic synced_o,
   output logic rise_o
);
   logic [STAGES-1:0] stage_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lw_sync_edge: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= 1'b1;
               else        stage_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[i] <= 1'b1;
               else        stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= stage_q[STAGES-1];
   end

   assign synced_o = stage_q[STAGES-1];
   assign rise_o   = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/lw_line_timer.sv
module lw_line_timer
   import lw_pkg::*;
#(
   parameter int unsigned BP_CYCLES    = 80,
   parameter int unsigned ACT_CYCLES   = 702,
   parameter bit          PORCH_RETRIG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   output logic porch_o,
   output logic active_o,
   output logic stb_o
);
   localparam int unsigned CMAX = lw_max(BP_CYCLES, ACT_CYCLES);
   localparam int unsigned CW   = (CMAX < 2) ? 1 : $clog2(CMAX);
   localparam logic [CW-1:0] BP_LOAD  = CW'(BP_CYCLES - 1);
   localparam logic [CW-1:0] ACT_LOAD = CW'(ACT_CYCLES - 1);

   tmr_state_e    st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          stb_q, stb_d;
   logic          restart;

   generate
      if (BP_CYCLES < 1) begin : g_bad_bp
         $error("lw_line_timer: BP_CYCLES must be at least 1");
      end
      if (ACT_CYCLES < 1) begin : g_bad_act
         $error("lw_line_timer: ACT_CYCLES must be at least 1");
      end
      if (PORCH_RETRIG) begin : g_retrig
         assign restart = rise_i;
      end else begin : g_oneshot
         assign restart = 1'b0;
      end
   endgenerate

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      stb_d = 1'b0;
      unique case (st_q)
         TMR_IDLE: begin
            if (rise_i) begin
               st_d  = TMR_PORCH;
               cnt_d = BP_LOAD;
            end
         end
         TMR_PORCH: begin
            if (restart) begin
               cnt_d = BP_LOAD;
            end else if (cnt_q == '0) begin
               st_d  = TMR_ACTIVE;
               cnt_d = ACT_LOAD;
               stb_d = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         TMR_ACTIVE: begin
            if (cnt_q == '0) st_d  = TMR_IDLE;
            else             cnt_d = cnt_q - 1'b1;
         end
         default: begin
            st_d  = TMR_IDLE;
            cnt_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TMR_IDLE;
         cnt_q <= '0;
         stb_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         stb_q <= stb_d;
      end
   end

   assign porch_o  = (st_q == TMR_PORCH);
   assign active_o = (st_q == TMR_ACTIVE);
   assign stb_o    = stb_q;

   // R3: the two windows never overlap
   a_r3_windows_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(porch_o && active_o));
   // R3: the end of the porch hands over to the active window
   a_r3_porch_cascade: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(porch_o) |-> active_o);
   // R5: an edge during the active window opens no porch
   a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && rise_i) |=> !porch_o);
   // R6: the active window is followed by idle
   a_r6_idle_after_active: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_o) |-> !porch_o);
   // R7: the strobe marks only the first active cycle
   a_r7_strobe_first_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |-> (active_o && !$past(active_o)));
   a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> !stb_o);
endmodule

// File: rtl/lw_vsync_integ.sv
module lw_vsync_integ #(
   parameter int unsigned INT_MAX = 1023,
   parameter int unsigned VS_ON   = 600,
   parameter int unsigned VS_OFF  = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_n_i,
   output logic vsync_o
);
   localparam int unsigned AW = $clog2(INT_MAX + 1);
   localparam logic [AW-1:0] MAX_A = AW'(INT_MAX);
   localparam logic [AW-1:0] ON_A  = AW'(VS_ON);
   localparam logic [AW-1:0] OFF_A = AW'(VS_OFF);

   logic [AW-1:0] acc_q;
   logic          vs_q;

   generate
      if (!(VS_OFF < VS_ON && VS_ON <= INT_MAX)) begin : g_bad_thresh
         $error("lw_vsync_integ: need VS_OFF < VS_ON <= INT_MAX");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (!sync_n_i) begin
         if (acc_q != MAX_A) acc_q <= acc_q + 1'b1;
      end else begin
         if (acc_q != '0) acc_q <= acc_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              vs_q <= 1'b0;
      else if (acc_q >= ON_A)  vs_q <= 1'b1;
      else if (acc_q <= OFF_A) vs_q <= 1'b0;
   end

   assign vsync_o = vs_q;

   // R8: count stays in range
   a_r8_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q <= MAX_A);
   // R8: low sync below saturation climbs by one
   a_r8_climb: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_n_i && acc_q != MAX_A) |=> acc_q == $past(acc_q) + 1'b1);
   // R9: set only after reaching the upper threshold
   a_r9_set_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vs_q) |-> $past(acc_q) >= ON_A);
   // R9: clear only after reaching the lower threshold
   a_r9_clear_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vs_q) |-> $past(acc_q) <= OFF_A);
endmodule

// File: rtl/sync_line_windows.sv
module sync_line_windows #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned BP_CYCLES    = 80,
   parameter int unsigned ACT_CYCLES   = 702,
   parameter bit          PORCH_RETRIG = 1'b1,
   parameter int unsigned INT_MAX      = 1023,
   parameter int unsigned VS_ON        = 600,
   parameter int unsigned VS_OFF       = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csync_n,
   output logic porch_o,
   output logic active_o,
   output logic line_stb_o,
   output logic vsync_o
);
   logic sync_s;
   logic sync_rise;

   lw_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (csync_n),
      .synced_o (sync_s),
      .rise_o   (sync_rise)
   );

   lw_line_timer #(
      .BP_CYCLES    (BP_CYCLES),
      .ACT_CYCLES   (ACT_CYCLES),
      .PORCH_RETRIG (PORCH_RETRIG)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (sync_rise),
      .porch_o  (porch_o),
      .active_o (active_o),
      .stb_o    (line_stb_o)
   );

   lw_vsync_integ #(
      .INT_MAX (INT_MAX),
      .VS_ON   (VS_ON),
      .VS_OFF  (VS_OFF)
   ) u_vs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_n_i (sync_s),
      .vsync_o  (vsync_o)
   );

   // R1: outputs quiet while reset is held
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> !(porch_o || active_o || line_stb_o || vsync_o));
endmodule

// File: tb/sync_line_windows_test.sv
module sync_line_windows_test;
   localparam int BP = 20;
   localparam int ACT = 150;
   localparam int IMAX = 255;
   localparam int ON = 120;
   localparam int OFF = 40;
   localparam int LIMIT = 200000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csync_n = 1'b1;
   logic porch_o, active_o, line_stb_o, vsync_o;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit done = 1'b0;

   sync_line_windows #(
      .SYNC_STAGES(2), .BP_CYCLES(BP), .ACT_CYCLES(ACT), .PORCH_RETRIG(1'b1),
      .INT_MAX(IMAX), .VS_ON(ON), .VS_OFF(OFF)
   ) uut (
      .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
      .porch_o(porch_o), .active_o(active_o),
      .line_stb_o(line_stb_o), .vsync_o(vsync_o)
   );

   always #5 clk = ~clk;

   // behavioural reference: mode 0 idle, 1 porch, 2 active
   bit m_d0, m_d1, m_prev;
   int m_mode, m_left, m_acc;
   bit m_stb, m_vs;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_d0 = 1; m_d1 = 1; m_prev = 1;
         m_mode = 0; m_left = 0; m_acc = 0; m_stb = 0; m_vs = 0;
      end else begin
         bit edge_seen;
         edge_seen = m_d1 && !m_prev;
         if (m_acc >= ON) m_vs = 1;
         else if (m_acc <= OFF) m_vs = 0;
         if (!m_d1) m_acc = (m_acc < IMAX) ? m_acc + 1 : IMAX;
         else       m_acc = (m_acc > 0) ? m_acc - 1 : 0;
         m_stb = 0;
         if (m_mode == 0) begin
            if (edge_seen) begin m_mode = 1; m_left = BP; end
         end else if (m_mode == 1) begin
            if (edge_seen) m_left = BP;
            else begin
               m_left--;
               if (m_left == 0) begin m_mode = 2; m_left = ACT; m_stb = 1; end
            end
         end else begin
            m_left--;
            if (m_left == 0) m_mode = 0;
         end
         m_prev = m_d1; m_d1 = m_d0; m_d0 = csync_n;
      end
   end

   task automatic check(input bit act, input bit exp, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0b expected %0b", what, cyc, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(porch_o,    (m_mode == 1), "R3/R4/R5 porch_o");
         check(active_o,   (m_mode == 2), "R3/R5/R6 active_o");
         check(line_stb_o, m_stb,         "R7 line_stb_o");
         check(vsync_o,    m_vs,          "R8/R9 vsync_o");
      end
   end

   int stb_count = 0;
   bit vs_seen = 0;
   always @(negedge clk) begin
      if (line_stb_o) stb_count++;
      if (vsync_o) vs_seen = 1;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > LIMIT && !done) begin
         done = 1;
         fails++;
         checks++;
         $display("FAIL watchdog expired: actual %0d cycles expected at most %0d", cyc, LIMIT);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic seg(input bit lvl, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         csync_n = lvl;
      end
   endtask

   task automatic plain_line();
      seg(0, 15); seg(1, 185);
   endtask

   task automatic spurious_line();
      seg(0, 15); seg(1, 60); seg(0, 5); seg(1, 10); seg(0, 5); seg(1, 105);
   endtask

   task automatic retrig_line();
      seg(0, 15); seg(1, 5); seg(0, 3); seg(1, 177);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      checks++;
      if ({porch_o, active_o, line_stb_o, vsync_o} !== 4'b0) begin
         fails++;
         $display("FAIL R1 reset outputs: actual %b expected 0000",
                  {porch_o, active_o, line_stb_o, vsync_o});
      end
      @(negedge clk) rst_n = 1'b1;
      seg(1, 50);
      // R2: no window without a rising edge
      checks++;
      if (porch_o || active_o) begin
         fails++;
         $display("FAIL R2 window before first edge: actual %b expected 00", {porch_o, active_o});
      end
      repeat (4) plain_line();
      stb_count = 0;
      repeat (3) spurious_line();
      // R5: spurious pulses add no lines
      checks++;
      if (stb_count != 3) begin
         fails++;
         $display("FAIL R5 strobes in spurious segment: actual %0d expected 3", stb_count);
      end
      repeat (2) retrig_line();
      repeat (2) plain_line();
      vs_seen = 0;
      repeat (6) begin seg(0, 85); seg(1, 15); end
      // R9: broad pulses raise vertical indication
      checks++;
      if (!vs_seen) begin
         fails++;
         $display("FAIL R9 vsync during broad pulses: actual 0 expected 1");
      end
      repeat (5) plain_line();
      // R9: indication cleared after normal lines
      checks++;
      if (vsync_o !== 1'b0) begin
         fails++;
         $display("FAIL R9 vsync after field: actual %b expected 0", vsync_o);
      end
      seg(1, 20);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule